// File: doc/BRIEF.md
# I2C Four-Channel Switch Controller

This block is an I2C target whose only payload is a four-bit channel-enable register. Each bit of the register turns on one downstream bus segment. The block samples SCL and SDA with the system clock through a two-flop synchroniser. It detects START and STOP conditions, shifts in the address byte and acknowledges when the address is its own. It then either takes written data bytes into the register or returns the register contents to the controller.

Written values are held as pending and reach the channel outputs only at the STOP that closes the transaction. This means a segment is never switched partway through a byte. Either of two active-low resets, an external pin or a power-on signal, clears the register and the bus state machine at once. Any reset therefore turns every channel off, even in the middle of a transfer.

SDA is driven open-drain: the block either pulls the line low or releases it.

Top module: `i2c_chan_switch`

## Requirements
- R1: After reset, `chan_en` is 0000 and `sda_oe` is 0. The block never pulls SDA low while idle.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START at any point, including a repeated START, restarts address reception. A STOP returns the block to idle with SDA released.
- R3: The 7-bit target address is {4'b1110, `addr_strap[2:0]`}. It is followed by the R/W bit, where 1 means read. The block pulls SDA low in the ninth clock only on a match. On a mismatch it drives nothing until the next START or STOP.
- R4: In a write, every data byte is acknowledged. Bit i of the byte (for i = 0..3) maps to `chan_en[i]`, and bits 7..4 are ignored.
- R5: A written value reaches `chan_en` only at the next STOP. Before that, `chan_en` keeps its old value. With several bytes, the last one wins.
- R6: In a read, the block sends {4'b0000, `chan_en`}, MSB first. It changes SDA only after SCL falls.
- R7: An acknowledge from the controller after a read byte makes the block send the value again. A missing acknowledge makes it release SDA and wait for a STOP or START.
- R8: `rst_ext_n` low clears `chan_en`, any pending write and the state machine, even in the middle of a transaction. After release, the next transaction is served normally.
- R9: `por_n` low has the same effect as `rst_ext_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_ext_n | input | 1 | External reset, active low, asynchronous |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_strap | input | 3 | Low three address bits |
| chan_en | output | 4 | Channel enables, bit i enables segment i |

## Verification
Two events can land in the same transaction window: the commit of a pending write at STOP, and an asynchronous reset. The bench provokes this by asserting the external reset while a data byte is half shifted in. It then finishes with a STOP and expects all channels to remain off, because the pending value must have been discarded. A second collision is a repeated START while a write is still pending. The read that follows must return the old enables, and the new value must appear only at the final STOP.

// File: rtl/i2c_chan_switch.sv
module i2c_chan_switch #(
  parameter int NCH = 4,
  parameter int STRAP_W = 3,
  parameter logic [6-STRAP_W:0] BASE_ADDR = 4'b1110
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               rst_ext_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] addr_strap,
  output logic [NCH-1:0]     chan_en
);
  localparam logic [2:0] ST_IDLE = 3'd0, ST_ADDR = 3'd1, ST_AACK = 3'd2, ST_WR = 3'd3,
                         ST_WACK = 3'd4, ST_RD = 3'd5, ST_RACK = 3'd6, ST_WAIT = 3'd7;

  logic       rst_n;
  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d, scl_s, sda_s;
  logic       start_det, stop_det, scl_rise, scl_fall;
  logic [2:0] state;
  logic [3:0] bitcnt;
  logic [7:0] shreg, tx_byte;
  logic [6:0] my_addr;
  logic       rw, mack, pend_v;
  logic [NCH-1:0] pend;

  assign rst_n     = por_n & rst_ext_n;
  assign scl_s     = scl_sy[1];
  assign sda_s     = sda_sy[1];
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign my_addr   = {BASE_ADDR, addr_strap};
  assign tx_byte   = {{(8-NCH){1'b0}}, chan_en};
  assign sda_oe    = (state == ST_AACK) | (state == ST_WACK) | ((state == ST_RD) & ~shreg[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      pend    <= '0;
      pend_v  <= 1'b0;
      chan_en <= '0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      bitcnt <= '0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      pend_v <= 1'b0;
      if (pend_v) chan_en <= pend;
    end else begin
      case (state)
        ST_ADDR, ST_WR: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            bitcnt <= '0;
            if (state == ST_ADDR) begin
              if (shreg[7:1] == my_addr) begin
                state <= ST_AACK;
                rw    <= shreg[0];
              end else begin
                state <= ST_WAIT;
              end
            end else begin
              state  <= ST_WACK;
              pend   <= shreg[NCH-1:0];
              pend_v <= 1'b1;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            if (rw) begin
              state <= ST_RD;
              shreg <= tx_byte;
            end else begin
              state <= ST_WR;
            end
          end
        end
        ST_WACK: if (scl_fall) state <= ST_WR;
        ST_RD: begin
          if (scl_fall) begin
            shreg <= {shreg[6:0], 1'b0};
            if (bitcnt == 4'd7) begin
              state  <= ST_RACK;
              bitcnt <= '0;
            end else begin
              bitcnt <= bitcnt + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              state <= ST_RD;
              shreg <= tx_byte;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_chan_switch_chk.sv
module i2c_chan_switch_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           por_n,
  input logic           rst_ext_n,
  input logic           sda_oe,
  input logic           stop_det,
  input logic [2:0]     st,
  input logic [3:0]     bitcnt,
  input logic [NCH-1:0] chan_en
);
  localparam logic [2:0] C_IDLE = 3'd0, C_RACK = 3'd6, C_WAIT = 3'd7;

  AST_RESET_OFF: assert property (@(posedge clk)
    !(por_n && rst_ext_n) |-> (chan_en == '0)); // R8

  AST_ENABLE_AT_STOP: assert property (@(posedge clk) disable iff (!(por_n && rst_ext_n))
    !$stable(chan_en) |-> $past(stop_det)); // R5

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!(por_n && rst_ext_n))
    (st == C_IDLE) |-> !sda_oe); // R1

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!(por_n && rst_ext_n))
    stop_det |=> (st == C_IDLE) && !sda_oe); // R2

  AST_NACK_RELEASED: assert property (@(posedge clk) disable iff (!(por_n && rst_ext_n))
    (st == C_RACK || st == C_WAIT) |-> !sda_oe); // R7

  AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (!(por_n && rst_ext_n))
    bitcnt <= 4'd8); // R3
endmodule

bind i2c_chan_switch i2c_chan_switch_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .por_n(por_n), .rst_ext_n(rst_ext_n), .sda_oe(sda_oe),
  .stop_det(stop_det), .st(state), .bitcnt(bitcnt), .chan_en(chan_en));

// File: tb/i2c_chan_switch_tb.sv
module i2c_chan_switch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam int NV = 6;
  // {addr7, data8, exp_addr_ack, exp_chan4}
  localparam logic [19:0] VEC [NV] = '{
    {7'b1110101, 8'h05, 1'b1, 4'h5},
    {7'b1110101, 8'hFA, 1'b1, 4'hA},
    {7'b1110100, 8'h0F, 1'b0, 4'hA},
    {7'b0110101, 8'h03, 1'b0, 4'hA},
    {7'b1110101, 8'h00, 1'b1, 4'h0},
    {7'b1110101, 8'h0F, 1'b1, 4'hF}
  };

  logic clk = 0, por_n = 0, rst_ext_n = 1, scl = 1, ctl_low = 0;
  logic [2:0] strap = 3'b101;
  logic sda_i, sda_oe;
  logic [3:0] chan_en;
  int errors = 0, checks = 0;
  bit done = 0;

  assign sda_i = ~(ctl_low | sda_oe);

  i2c_chan_switch u_dut (.clk(clk), .por_n(por_n), .rst_ext_n(rst_ext_n), .scl_i(scl),
    .sda_i(sda_i), .sda_oe(sda_oe), .addr_strap(strap), .chan_en(chan_en));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    ctl_low = 0; scl = 1; waitq(2*Q);
    ctl_low = 1; waitq(Q);
    scl = 0; waitq(Q);
  endtask

  task automatic bus_stop();
    ctl_low = 1; waitq(Q);
    scl = 1; waitq(Q);
    ctl_low = 0; waitq(2*Q);
  endtask

  task automatic bit_xfer(input logic b, output logic s);
    ctl_low = ~b; waitq(Q);
    scl = 1; waitq(Q);
    s = sda_i; waitq(Q);
    scl = 0; waitq(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_xfer(d[i], s);
    bit_xfer(1'b1, s);
    ack = ~s;
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, s);
      d[i] = s;
    end
    bit_xfer(~give_ack, s);
  endtask

  task automatic write_one(input logic [6:0] a, input logic [7:0] d, output logic aack, output logic dack);
    bus_start();
    send_byte({a, 1'b0}, aack);
    send_byte(d, dack);
    bus_stop();
  endtask

  task automatic read_one(input logic [6:0] a, output logic [7:0] d);
    logic ack;
    bus_start();
    send_byte({a, 1'b1}, ack);
    read_byte(1'b0, d);
    bus_stop();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic aack, dack, s;
    logic [7:0] rd;
    logic [3:0] exp_ch;
    waitq(4);
    check(chan_en == 4'h0, "R1 reset chan_en", chan_en, 0);
    check(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
    por_n = 1;
    waitq(4);

    for (int v = 0; v < NV; v++) begin
      write_one(VEC[v][19:13], VEC[v][12:5], aack, dack);
      check(aack == VEC[v][4], "R3 address ack", aack, VEC[v][4]);
      check(dack == VEC[v][4], "R4 data ack", dack, VEC[v][4]);
      check(chan_en == VEC[v][3:0], "R4 chan_en after STOP", chan_en, VEC[v][3:0]);
      read_one(7'b1110101, rd);
      check(rd == {4'h0, VEC[v][3:0]}, "R6 readback", rd, {4'h0, VEC[v][3:0]});
    end

    // R5: two bytes in one write, applied only at STOP
    bus_start();
    send_byte({7'b1110101, 1'b0}, aack);
    send_byte(8'h01, dack);
    check(chan_en == 4'hF, "R5 unchanged before STOP", chan_en, 4'hF);
    send_byte(8'h02, dack);
    check(dack && chan_en == 4'hF, "R5 unchanged after second byte", chan_en, 4'hF);
    bus_stop();
    check(chan_en == 4'h2, "R5 last byte wins", chan_en, 4'h2);

    // R2: repeated START with a write pending
    bus_start();
    send_byte({7'b1110101, 1'b0}, aack);
    send_byte(8'h0C, dack);
    bus_start();
    send_byte({7'b1110101, 1'b1}, aack);
    check(aack == 1'b1, "R2 repeated START addressed", aack, 1);
    read_byte(1'b0, rd);
    check(rd == 8'h02, "R2 read after repeated START sees old value", rd, 8'h02);
    bus_stop();
    check(chan_en == 4'hC, "R5 pending applied at final STOP", chan_en, 4'hC);

    // R7: acknowledged read repeats, no-ack releases SDA
    bus_start();
    send_byte({7'b1110101, 1'b1}, aack);
    read_byte(1'b1, rd);
    check(rd == 8'h0C, "R7 first read byte", rd, 8'h0C);
    read_byte(1'b0, rd);
    check(rd == 8'h0C, "R7 second read byte", rd, 8'h0C);
    waitq(Q);
    check(sda_oe == 1'b0, "R7 SDA released after no-ack", sda_oe, 0);
    bit_xfer(1'b1, s);
    check(s == 1'b1, "R7 no drive in extra clock", s, 1);
    bus_stop();

    // R3: strap change moves the address
    strap = 3'b010;
    write_one(7'b1110101, 8'h01, aack, dack);
    check(aack == 1'b0 && chan_en == 4'hC, "R3 old address ignored", chan_en, 4'hC);
    write_one(7'b1110010, 8'h03, aack, dack);
    check(aack == 1'b1 && chan_en == 4'h3, "R3 new strap address", chan_en, 4'h3);

    // R8: external reset in the middle of a data byte with a write pending
    bus_start();
    send_byte({7'b1110010, 1'b0}, aack);
    send_byte(8'h0E, dack);
    for (int i = 7; i >= 4; i--) bit_xfer(1'b1, s);
    rst_ext_n = 0;
    waitq(3);
    check(chan_en == 4'h0, "R8 reset clears enables mid-transaction", chan_en, 0);
    check(sda_oe == 1'b0, "R8 reset releases SDA", sda_oe, 0);
    rst_ext_n = 1;
    waitq(2);
    bus_stop();
    check(chan_en == 4'h0, "R8 pending write discarded", chan_en, 0);
    write_one(7'b1110010, 8'h06, aack, dack);
    check(chan_en == 4'h6, "R8 normal service after reset", chan_en, 6);

    // R9: power-on reset
    exp_ch = 4'h0;
    por_n = 0;
    waitq(3);
    check(chan_en == exp_ch, "R9 POR clears enables", chan_en, exp_ch);
    por_n = 1;
    waitq(3);
    read_one(7'b1110010, rd);
    check(rd == 8'h00, "R9 readback after POR", rd, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule